// File: doc/BRIEF.md
# Addend-Tuned Precision Time Clock

This block keeps a free-running 64-bit system time for a precision time protocol node. One unit of the count is 32 ns. Each cycle of the reference clock, a 32-bit fractional accumulator takes in a programmable rate word. Every carry out of that accumulator steps the time by one count. Software tunes the clock rate by nudging the rate word around its nominal value. Software also steps the clock by writing a new 64-bit time, which commits as a single atomic update.

Two asynchronous auxiliary inputs capture the running time on their rising edges. Each input has its own snapshot register pair, so a host can timestamp external pulses. A programmable 64-bit target time raises a flag when the clock arrives at it. A per-period pulse flag marks each rollover of a configurable number of low time bits. All four flags are write-one-to-clear. Each is gated onto a single interrupt line by its own mask bit.

Access goes through a simple word-indexed register port. Reads return data one cycle after the read strobe.

Top module: `tsync_clock`

## Requirements
- R1: After the asynchronous reset, the control word (index 0) and the event word (index 1) read zero, and irq_o is low.
- R2: The rate word (index 2) resets to 0xA0000000. It reads back whatever was written. Register indices 2, 5 and 6 (target time low and high) are read/write. Control index 0 keeps only bits 4:1; bit 0 is soft reset, and all other bits read zero.
- R3: Each reference cycle adds the rate word to the accumulator modulo 2^32. Each carry steps the time by exactly one. With a rate word of 0, the time holds. With 0x40000000, the time advances by 100 counts in 400 cycles.
- R4: A write to time-high (index 4) is held and does not change the time. A later write to time-low (index 3) loads both halves at once.
- R5: A read of time-low (index 3) returns the low word and latches the high word into a shadow. A read of time-high (index 4) returns that shadow, even if the time changed in between.
- R6: A rising edge on aux_slave_i captures the time into indices 7 (low) and 8 (high) and sets event bit 2. A rising edge on aux_master_i captures into indices 9 and 10 and sets event bit 3. The capture happens three cycles after the input rises.
- R7: An auxiliary input held high captures only once. A new edge overwrites an unread snapshot.
- R8: When the time takes a value equal to the target (indices 5 and 6), by stepping or by loading, event bit 1 sets.
- R9: Writing 1 to an event bit clears that bit only. Writing 0 to an event bit has no effect, and a write to the event word can never set a flag.
- R10: irq_o is high exactly when some event bit n (n in 1..4) is set and control bit n is set.
- R11: Event bit 4 sets when a step of the time makes its low PPS_BITS bits all zero.
- R12: While control bit 0 is 1, the time, the accumulator, the snapshots and the event flags are held at zero, and time writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_idx_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_re_i |
| aux_slave_i | input | 1 | Asynchronous slave capture input |
| aux_master_i | input | 1 | Asynchronous master capture input |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The bench reads the time high word after the time has been reloaded between the two halves of a read. A design without the shadow would return the new high word instead of the one latched with the low read. It writes only the high half of the time and expects no change. A design that commits on either half would show a torn value. It holds an auxiliary input high across a cleared flag to catch designs that capture on level rather than edge. It also loads the time a few counts below a period rollover and expects the period flag. It writes 1 to a single event bit while two are pending to expose clears that reach neighbouring flags.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned TW = 64;
  localparam int unsigned IW = 4;
  localparam int unsigned NEV = 4;

  localparam logic [IW-1:0] IDX_CTRL   = 4'd0;
  localparam logic [IW-1:0] IDX_EVENT  = 4'd1;
  localparam logic [IW-1:0] IDX_RATE   = 4'd2;
  localparam logic [IW-1:0] IDX_TLO    = 4'd3;
  localparam logic [IW-1:0] IDX_THI    = 4'd4;
  localparam logic [IW-1:0] IDX_TGTLO  = 4'd5;
  localparam logic [IW-1:0] IDX_TGTHI  = 4'd6;
  localparam logic [IW-1:0] IDX_SLVLO  = 4'd7;
  localparam logic [IW-1:0] IDX_SLVHI  = 4'd8;
  localparam logic [IW-1:0] IDX_MSTLO  = 4'd9;
  localparam logic [IW-1:0] IDX_MSTHI  = 4'd10;

  // flag vector order; register bit = index + 1
  typedef enum int unsigned {EV_TGT = 0, EV_SLV = 1, EV_MST = 2, EV_PPS = 3} ev_e;

  localparam logic [DW-1:0] RATE_RST = 32'hA000_0000;
endpackage

// File: rtl/tsync_timebase.sv
module tsync_timebase
  import tsync_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [ACC_W-1:0] rate_i,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [ACC_W-1:0] wdata_i,
  output logic [CNT_W-1:0] time_o,
  output logic             step_o,
  output logic             load_o
);
  localparam int unsigned HI_W = CNT_W - ACC_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [HI_W-1:0]  hi_hold_q;
  logic [CNT_W-1:0] time_q;
  logic             step_q, load_q;

  assign sum = {1'b0, acc_q} + {1'b0, rate_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      hi_hold_q <= '0;
      time_q    <= '0;
      step_q    <= 1'b0;
      load_q    <= 1'b0;
    end else if (srst_i) begin
      acc_q     <= '0;
      hi_hold_q <= '0;
      time_q    <= '0;
      step_q    <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      step_q <= 1'b0;
      load_q <= 1'b0;
      if (hi_we_i) hi_hold_q <= wdata_i[HI_W-1:0];
      if (lo_we_i) begin
        time_q <= {hi_hold_q, wdata_i};
        load_q <= 1'b1;
      end else if (sum[ACC_W]) begin
        time_q <= time_q + 1'b1;
        step_q <= 1'b1;
      end
    end
  end

  assign time_o = time_q;
  assign step_o = step_q;
  assign load_o = load_q;
endmodule

// File: rtl/tsync_aux_capture.sv
module tsync_aux_capture #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] time_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] snap_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       snap_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q & ~srst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (srst_i) snap_q <= '0;
    else if (rise_o) snap_q <= time_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/tsync_events.sv
module tsync_events #(
  parameter int unsigned NEV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           srst_i,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  input  logic [NEV-1:0] mask_i,
  output logic [NEV-1:0] flags_o,
  output logic           irq_o
);
  logic [NEV-1:0] flags_q;

  generate
    for (genvar i = 0; i < NEV; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q[i] <= 1'b0;
        else if (srst_i) flags_q[i] <= 1'b0;
        else if (set_i[i]) flags_q[i] <= 1'b1;  // set wins over clear
        else if (clr_i[i]) flags_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_i);
endmodule

// File: rtl/tsync_clock.sv
module tsync_clock
  import tsync_pkg::*;
#(
  parameter int unsigned PPS_BITS = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [IW-1:0] reg_idx_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          aux_slave_i,
  input  logic          aux_master_i,
  output logic          irq_o
);
  localparam int unsigned HI_W = TW - DW;

  logic [NEV:0]   ctrl_q;
  logic [DW-1:0]  rate_q;
  logic [TW-1:0]  tgt_q;
  logic [HI_W-1:0] shadow_q;
  logic [DW-1:0]  rdata_q;
  logic           srst;

  logic [TW-1:0]  time_w, snap_slv, snap_mst;
  logic           step_w, load_w, rise_slv, rise_mst;
  logic [NEV-1:0] ev_set, ev_clr, flags_w;
  logic           ev_we, tlo_we, thi_we;

  assign srst   = ctrl_q[0];
  assign ev_we  = reg_we_i && (reg_idx_i == IDX_EVENT);
  assign tlo_we = reg_we_i && (reg_idx_i == IDX_TLO);
  assign thi_we = reg_we_i && (reg_idx_i == IDX_THI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rate_q <= RATE_RST;
      tgt_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_idx_i)
        IDX_CTRL:  ctrl_q <= reg_wdata_i[NEV:0];
        IDX_RATE:  rate_q <= reg_wdata_i;
        IDX_TGTLO: tgt_q[DW-1:0] <= reg_wdata_i;
        IDX_TGTHI: tgt_q[TW-1:DW] <= reg_wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  tsync_timebase #(.ACC_W(DW), .CNT_W(TW)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst),
    .rate_i  (rate_q),
    .hi_we_i (thi_we),
    .lo_we_i (tlo_we),
    .wdata_i (reg_wdata_i),
    .time_o  (time_w),
    .step_o  (step_w),
    .load_o  (load_w)
  );

  tsync_aux_capture #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(TW)) u_cap_slv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .pin_i  (aux_slave_i),
    .time_i (time_w),
    .rise_o (rise_slv),
    .snap_o (snap_slv)
  );

  tsync_aux_capture #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(TW)) u_cap_mst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .pin_i  (aux_master_i),
    .time_i (time_w),
    .rise_o (rise_mst),
    .snap_o (snap_mst)
  );

  always_comb begin
    ev_set = '0;
    ev_set[EV_TGT] = (step_w | load_w) && (time_w == tgt_q);
    ev_set[EV_SLV] = rise_slv;
    ev_set[EV_MST] = rise_mst;
    ev_set[EV_PPS] = step_w && (time_w[PPS_BITS-1:0] == '0);
  end

  assign ev_clr = ev_we ? reg_wdata_i[NEV:1] : '0;

  tsync_events #(.NEV(NEV)) u_ev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst),
    .set_i   (ev_set),
    .clr_i   (ev_clr),
    .mask_i  (ctrl_q[NEV:1]),
    .flags_o (flags_w),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (reg_re_i) begin
      rdata_q <= '0;
      case (reg_idx_i)
        IDX_CTRL:  rdata_q <= {{(DW-NEV-1){1'b0}}, ctrl_q};
        IDX_EVENT: rdata_q <= {{(DW-NEV-1){1'b0}}, flags_w, 1'b0};
        IDX_RATE:  rdata_q <= rate_q;
        IDX_TLO: begin
          rdata_q  <= time_w[DW-1:0];
          shadow_q <= time_w[TW-1:DW];
        end
        IDX_THI:   rdata_q <= shadow_q;
        IDX_TGTLO: rdata_q <= tgt_q[DW-1:0];
        IDX_TGTHI: rdata_q <= tgt_q[TW-1:DW];
        IDX_SLVLO: rdata_q <= snap_slv[DW-1:0];
        IDX_SLVHI: rdata_q <= snap_slv[TW-1:DW];
        IDX_MSTLO: rdata_q <= snap_mst[DW-1:0];
        IDX_MSTHI: rdata_q <= snap_mst[TW-1:DW];
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/tsync_clock_chk.sv
module tsync_clock_chk
  import tsync_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           srst,
  input logic [TW-1:0]  time_w,
  input logic           tlo_we,
  input logic [NEV-1:0] flags_w,
  input logic           rise_slv,
  input logic           ev_we,
  input logic [DW-1:0]  reg_wdata_i,
  input logic           irq_o,
  input logic [TW-1:0]  snap_slv
);
  // R3: time moves by at most one count unless loaded
  assert_time_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst && !tlo_we) |=> (time_w == $past(time_w) || time_w == $past(time_w) + 64'd1));

  // R6: snapshot changes only on a captured edge
  assert_snap_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_slv && !srst) |=> $stable(snap_slv));

  // R9: a one written to the slave flag clears it when no new edge arrives
  assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_we && reg_wdata_i[2] && !rise_slv) |=> !flags_w[EV_SLV]);

  // R10: interrupt only with a pending flag
  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_w != '0));

  // R12: soft reset zeroes time and flags
  assert_srst_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (time_w == '0 && flags_w == '0));
endmodule

bind tsync_clock tsync_clock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .srst        (srst),
  .time_w      (time_w),
  .tlo_we      (tlo_we),
  .flags_w     (flags_w),
  .rise_slv    (rise_slv),
  .ev_we       (ev_we),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .snap_slv    (snap_slv)
);

// File: tb/tsync_clock_test.sv
module tsync_clock_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 6;
  // {index, write data, expected read}
  localparam logic [67:0] VEC [NVEC] = '{
    {4'd2, 32'h1234_5678, 32'h1234_5678},
    {4'd5, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd6, 32'h0000_CAFE, 32'h0000_CAFE},
    {4'd0, 32'h0000_001E, 32'h0000_001E},
    {4'd0, 32'hFFFF_FFE0, 32'h0000_0000},
    {4'd1, 32'h0000_001E, 32'h0000_0000}
  };

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, aux_s = 0, aux_m = 0;
  logic [3:0] idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  tsync_clock uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_idx_i(idx), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .aux_slave_i(aux_s), .aux_master_i(aux_m), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] d);
    @(negedge clk); we = 1; idx = i; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [3:0] i, output logic [31:0] d);
    @(negedge clk); re = 1; idx = i;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, a, b;
    rst_n = 0; idle(3); rst_n = 1;
    // R1 / R2 reset state
    rd(4'd0, v); check("R1 ctrl", v, 0);
    rd(4'd1, v); check("R1 event", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(4'd2, v); check("R2 rate reset", v, 32'hA000_0000);
    // R2 / R9 register vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][67:64], VEC[k][63:32]);
      rd(VEC[k][67:64], v);
      check((VEC[k][67:64] == 4'd1) ? "R9 no set by write" : "R2 readback", v, VEC[k][31:0]);
    end
    wr(4'd0, 0);
    // R3 freeze with rate 0
    wr(4'd2, 0);
    rd(4'd3, a); idle(20); rd(4'd3, b);
    check("R3 hold", b, a);
    // R4 atomic load
    wr(4'd4, 32'h2); wr(4'd3, 32'h10);
    rd(4'd3, v); check("R4 lo", v, 32'h10);
    rd(4'd4, v); check("R4 hi", v, 32'h2);
    // R5 shadow survives a reload
    rd(4'd3, v);
    wr(4'd4, 32'h7); wr(4'd3, 32'h20);
    rd(4'd4, v); check("R5 shadow", v, 32'h2);
    // R4 high write alone does nothing
    wr(4'd4, 32'h9);
    rd(4'd3, v); check("R4 hi-only lo", v, 32'h20);
    rd(4'd4, v); check("R4 hi-only hi", v, 32'h7);
    wr(4'd3, 32'h30);
    rd(4'd3, v); check("R4 commit lo", v, 32'h30);
    rd(4'd4, v); check("R4 commit hi", v, 32'h9);
    // R6 slave capture, time frozen at 0x9_00000030
    @(negedge clk); aux_s = 1; idle(5);
    rd(4'd7, v); check("R6 slave lo", v, 32'h30);
    rd(4'd8, v); check("R6 slave hi", v, 32'h9);
    rd(4'd1, v); check("R6 slave flag", v, 32'h4);
    // R7 level held: clear and no recapture
    wr(4'd1, 32'h4); idle(5);
    rd(4'd1, v); check("R7 level once", v, 0);
    // R6 master capture
    @(negedge clk); aux_m = 1; idle(5);
    rd(4'd9, v); check("R6 master lo", v, 32'h30);
    rd(4'd10, v); check("R6 master hi", v, 32'h9);
    // R7 new edge overwrites unread snapshot
    wr(4'd3, 32'h44);
    @(negedge clk); aux_s = 0; idle(3); aux_s = 1; idle(5);
    rd(4'd7, v); check("R7 overwrite", v, 32'h44);
    // R9 clear one of two pending
    wr(4'd1, 32'h4);
    rd(4'd1, v); check("R9 w1c single", v, 32'h8);
    wr(4'd1, 32'h0);
    rd(4'd1, v); check("R9 zero write", v, 32'h8);
    // R10 masking
    check("R10 masked", {31'd0, irq}, 0);
    wr(4'd0, 32'h8); @(negedge clk);
    check("R10 unmasked", {31'd0, irq}, 1);
    wr(4'd0, 32'h4); @(negedge clk);
    check("R10 other mask", {31'd0, irq}, 0);
    wr(4'd1, 32'h1E); wr(4'd0, 0);
    // R8 target hit on load
    wr(4'd5, 32'h55); wr(4'd6, 32'h1);
    rd(4'd1, v); check("R8 before", v, 0);
    wr(4'd4, 32'h1); wr(4'd3, 32'h55); idle(2);
    rd(4'd1, v); check("R8 target flag", v, 32'h2);
    wr(4'd1, 32'h2);
    // R11 period rollover
    wr(4'd4, 0); wr(4'd3, 32'h01FF_FFFD);
    wr(4'd2, 32'h8000_0000); idle(12);
    rd(4'd1, v); check("R11 pps flag", v, 32'h10);
    // R3 rate
    wr(4'd2, 32'h4000_0000); idle(4);
    rd(4'd3, a); idle(399); rd(4'd3, b);
    check("R3 rate", ((b - a) == 100 || (b - a) == 101) ? 1 : 0, 1);
    // R12 soft reset
    wr(4'd0, 32'h1); idle(2);
    rd(4'd3, v); check("R12 time", v, 0);
    rd(4'd1, v); check("R12 flags", v, 0);
    wr(4'd3, 32'h77);
    rd(4'd3, v); check("R12 write ignored", v, 0);
    wr(4'd0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule